// File: doc/BRIEF.md
# Timed Test Coprocessor

This block sits on a simple CPU coprocessor port and answers two coprocessor numbers: a main one (4) and an auxiliary one (5). It holds sixteen 32-bit general registers. The CPU can move words into and out of them, stream words from or to memory through them, and issue data-processing operations. A data-processing operation can stall the CPU for a number of cycles held in a register. It can also pull the active-low fast or normal interrupt line after a programmed delay, release either line, or copy a free-running cycle counter into a register. Software test suites use it to generate stalls and interrupts with exact timing.

Each request lasts one cycle. It carries a kind, a phase bit, the coprocessor number, the instruction word and write data. Exactly one registered response follows in the next cycle: done, busy (stall, poll again), more (send the next word) or cannot-handle (the CPU takes its undefined-instruction trap). Read data arrives with the response.

Request kinds on `req_kind`: 0 register put (CPU to coprocessor), 1 register get, 2 memory load, 3 memory store, 4 data-processing; values 5 to 7 are unused. Instruction fields: opcode in bits 23:20, move index in bits 19:16, transfer index in bits 15:12, count-register index in bits 3:0, and bit 22 selects a long transfer.

Top module: `tcp_timed_copro`

## Requirements
- R1: While reset is high and after it, all sixteen registers read zero, both interrupt lines are high, no response is flagged and the cycle counter starts from zero.
- R2: A put (kind 0) on coprocessor 4 or 5 writes `req_wdata` into the register named by bits 19:16 and answers done. A get (kind 1) answers done and returns that register on `resp_rdata` in the response cycle.
- R3: Any request on a coprocessor number other than 4 and 5, and any kind value from 5 to 7, is answered cannot-handle.
- R4: Loads and stores are served only on coprocessor 4, and coprocessor 5 answers them cannot-handle. A data beat (phase 1) of a load writes `req_wdata` into the register named by bits 15:12. A data beat of a store returns that register on `resp_rdata`.
- R5: With bit 22 set, the data beats of a transfer answer more until the fifth, which answers done. With bit 22 clear, each data beat answers done.
- R6: An address phase (phase 0) of a load or store on coprocessor 4 answers done and restarts the long-transfer beat count at zero.
- R7: Opcode 0 on either coprocessor with phase 0 records start plus count, where the count comes from the register named by bits 3:0. It answers done if the count is zero and busy otherwise. Each phase-1 poll answers busy until the cycle counter reaches that target, then done.
- R8: Opcode 1 on coprocessor 5 drives `fiq_n` low exactly N clock edges after the request edge, where N is the count register value. With N zero, the line falls on the request edge.
- R9: Opcode 2 on coprocessor 5 does the same for `irq_n`.
- R10: Opcodes 3 and 4 on coprocessor 5 drive `fiq_n` and `irq_n` high and answer done. On coprocessor 4, every data-processing opcode other than 0 answers cannot-handle, and so do opcodes 6 to 15 on coprocessor 5.
- R11: Opcode 5 on coprocessor 5 writes the cycle counter value of the request edge into the register named by bits 3:0. The counter advances by one every clock edge out of reset.
- R12: A new schedule for a line replaces its pending event, even on the edge where that event would have fired. If a pending event fires on the same edge as a release of its line, the line goes low.
- R13: When `resp_valid` is high, exactly one of done, busy, more and cannot-handle is high. When it is low, none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request kind (0 put, 1 get, 2 load, 3 store, 4 data-processing) |
| req_phase | input | 1 | 0 first/address phase, 1 data beat or stall poll |
| req_cpnum | input | 4 | Coprocessor number addressed |
| req_instr | input | 32 | Instruction word |
| req_wdata | input | 32 | Write data for put and load beats |
| resp_valid | output | 1 | Response present |
| resp_done | output | 1 | Request completed |
| resp_busy | output | 1 | Stall in progress, poll again |
| resp_more | output | 1 | Long transfer wants another word |
| resp_cant | output | 1 | Request not handled |
| resp_rdata | output | 32 | Register data for get and store beats |
| fiq_n | output | 1 | Fast interrupt, active low |
| irq_n | output | 1 | Normal interrupt, active low |

## Verification
A timed interrupt event can fall due on the very edge where the CPU releases the same line or reschedules it, so the line's timer and the request decoder act on one edge. The bench provokes both cases. It schedules a two-cycle event and then places the release or a fresh schedule exactly on the second edge after the request. A behavioural model, updated on every edge, predicts the line level, and the bench compares it each cycle. The release must lose to the firing event, and the reschedule must cancel it, so the line stays high until the new delay runs out.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  typedef enum logic [2:0] {
    K_PUT   = 3'd0,
    K_GET   = 3'd1,
    K_LOAD  = 3'd2,
    K_STORE = 3'd3,
    K_OP    = 3'd4
  } kind_e;

  typedef enum logic [3:0] {
    A_CANT,
    A_PUT,
    A_GET,
    A_XFER_ADDR,
    A_LOAD_BEAT,
    A_STORE_BEAT,
    A_STALL_START,
    A_STALL_POLL,
    A_SCHED_F,
    A_SCHED_I,
    A_CLEAR_F,
    A_CLEAR_I,
    A_SNAP
  } act_e;

  typedef struct packed {
    logic done;
    logic busy;
    logic more;
    logic cant;
  } resp_t;

endpackage

// File: rtl/tcp_decode.sv
module tcp_decode
  import tcp_pkg::*;
#(
  parameter int CP_MAIN = 4,
  parameter int CP_AUX  = 5
) (
  input  logic [2:0] kind,
  input  logic       phase,
  input  logic [3:0] cpnum,
  input  logic [3:0] opc,
  output act_e       act
);

  logic is_main, is_aux;

  always_comb begin
    is_main = (cpnum == 4'(CP_MAIN));
    is_aux  = (cpnum == 4'(CP_AUX));
    act     = A_CANT;
    if (is_main || is_aux) begin
      case (kind)
        K_PUT:   act = A_PUT;
        K_GET:   act = A_GET;
        K_LOAD:  if (is_main) act = phase ? A_LOAD_BEAT  : A_XFER_ADDR;
        K_STORE: if (is_main) act = phase ? A_STORE_BEAT : A_XFER_ADDR;
        K_OP: begin
          if (opc == 4'd0) act = phase ? A_STALL_POLL : A_STALL_START;
          else if (is_aux) begin
            case (opc)
              4'd1:    act = A_SCHED_F;
              4'd2:    act = A_SCHED_I;
              4'd3:    act = A_CLEAR_F;
              4'd4:    act = A_CLEAR_I;
              4'd5:    act = A_SNAP;
              default: act = A_CANT;
            endcase
          end
        end
        default: act = A_CANT;
      endcase
    end
  end

endmodule

// File: rtl/tcp_regbank.sv
module tcp_regbank #(
  parameter int W  = 32,
  parameter int N  = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/tcp_alarm.sv
module tcp_alarm #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sched,
  input  logic [W-1:0] delay,
  input  logic         clear,
  output logic         line_n
);

  logic         pend;
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      left   <= '0;
      line_n <= 1'b1;
    end else if (sched) begin
      if (delay == '0) begin
        line_n <= 1'b0;
        pend   <= 1'b0;
      end else begin
        pend <= 1'b1;
        left <= delay;
      end
    end else if (pend && left == W'(1)) begin
      line_n <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (pend) left <= left - W'(1);
      if (clear) line_n <= 1'b1;
    end
  end

  // R8
  alarm_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(line_n) |-> ($past(sched && delay == '0) || $past(!sched && pend && left == W'(1))));

  // R10
  alarm_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(line_n) |-> $past(clear));

  // R12
  alarm_reload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sched && delay != '0) |=> $stable(line_n));

endmodule

// File: rtl/tcp_timed_copro.sv
module tcp_timed_copro
  import tcp_pkg::*;
#(
  parameter int W          = 32,
  parameter int NREG       = 16,
  parameter int LONG_BEATS = 5,
  parameter int CP_MAIN    = 4,
  parameter int CP_AUX     = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [2:0]   req_kind,
  input  logic         req_phase,
  input  logic [3:0]   req_cpnum,
  input  logic [31:0]  req_instr,
  input  logic [W-1:0] req_wdata,
  output logic         resp_valid,
  output logic         resp_done,
  output logic         resp_busy,
  output logic         resp_more,
  output logic         resp_cant,
  output logic [W-1:0] resp_rdata,
  output logic         fiq_n,
  output logic         irq_n
);

  localparam int AW = $clog2(NREG);
  localparam int BW = (LONG_BEATS > 1) ? $clog2(LONG_BEATS) : 1;

  // instruction fields
  logic [3:0]    opc;
  logic [AW-1:0] idx_move, idx_xfer, idx_cnt;
  logic          long_xfer;
  logic          unused_instr;

  assign opc          = req_instr[23:20];
  assign idx_move     = req_instr[16 +: AW];
  assign idx_xfer     = req_instr[12 +: AW];
  assign idx_cnt      = req_instr[0 +: AW];
  assign long_xfer    = req_instr[22];
  assign unused_instr = ^{req_instr[31:24], req_instr[11:4]};

  act_e act;

  tcp_decode #(.CP_MAIN(CP_MAIN), .CP_AUX(CP_AUX)) u_decode (
    .kind  (req_kind),
    .phase (req_phase),
    .cpnum (req_cpnum),
    .opc   (opc),
    .act   (act)
  );

  logic         go;
  logic [W-1:0] cyc, finish, rd_a, cnt_val;
  logic [BW-1:0] beat;
  logic          we;
  logic [AW-1:0] waddr, raddr_a;
  logic [W-1:0]  wdata;
  resp_t         resp_n;
  logic          beat_op, last_beat;

  assign go      = req_valid;
  assign beat_op = (act == A_LOAD_BEAT) || (act == A_STORE_BEAT);
  assign last_beat = (beat == BW'(LONG_BEATS - 1));

  // register bank ports
  always_comb begin
    raddr_a = (act == A_GET) ? idx_move : idx_xfer;
    we      = go && (act == A_PUT || act == A_LOAD_BEAT || act == A_SNAP);
    case (act)
      A_PUT:   waddr = idx_move;
      A_SNAP:  waddr = idx_cnt;
      default: waddr = idx_xfer;
    endcase
    wdata = (act == A_SNAP) ? cyc : req_wdata;
  end

  tcp_regbank #(.W(W), .N(NREG)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .raddr_a (raddr_a),
    .rdata_a (rd_a),
    .raddr_b (idx_cnt),
    .rdata_b (cnt_val)
  );

  // response selection
  always_comb begin
    resp_n = '0;
    case (act)
      A_CANT:        resp_n.cant = 1'b1;
      A_LOAD_BEAT,
      A_STORE_BEAT: begin
        if (long_xfer && !last_beat) resp_n.more = 1'b1;
        else                         resp_n.done = 1'b1;
      end
      A_STALL_START: begin
        if (cnt_val == '0) resp_n.done = 1'b1;
        else               resp_n.busy = 1'b1;
      end
      A_STALL_POLL: begin
        if (cyc >= finish) resp_n.done = 1'b1;
        else               resp_n.busy = 1'b1;
      end
      default:       resp_n.done = 1'b1;
    endcase
  end

  // counters and response register
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc        <= '0;
      finish     <= '0;
      beat       <= '0;
      resp_valid <= 1'b0;
      resp_done  <= 1'b0;
      resp_busy  <= 1'b0;
      resp_more  <= 1'b0;
      resp_cant  <= 1'b0;
      resp_rdata <= '0;
    end else begin
      cyc        <= cyc + W'(1);
      resp_valid <= go;
      resp_done  <= go && resp_n.done;
      resp_busy  <= go && resp_n.busy;
      resp_more  <= go && resp_n.more;
      resp_cant  <= go && resp_n.cant;
      resp_rdata <= (go && (act == A_GET || act == A_STORE_BEAT)) ? rd_a : '0;
      if (go && act == A_STALL_START) finish <= cyc + cnt_val;
      if (go && act == A_XFER_ADDR) beat <= '0;
      else if (go && beat_op) begin
        if (long_xfer && !last_beat) beat <= beat + BW'(1);
        else                         beat <= '0;
      end
    end
  end

  // interrupt timers, one per line
  tcp_alarm #(.W(W)) u_fiq_alarm (
    .clk    (clk),
    .rst    (rst),
    .sched  (go && act == A_SCHED_F),
    .delay  (cnt_val),
    .clear  (go && act == A_CLEAR_F),
    .line_n (fiq_n)
  );

  tcp_alarm #(.W(W)) u_irq_alarm (
    .clk    (clk),
    .rst    (rst),
    .sched  (go && act == A_SCHED_I),
    .delay  (cnt_val),
    .clear  (go && act == A_CLEAR_I),
    .line_n (irq_n)
  );

  // R13
  resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $countones({resp_done, resp_busy, resp_more, resp_cant}) == 1);

  // R13
  resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> {resp_done, resp_busy, resp_more, resp_cant} == 4'b0);

  // R3
  foreign_cp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cpnum != 4'(CP_MAIN) && req_cpnum != 4'(CP_AUX)) |=> resp_cant);

  // R5
  beat_range_chk: assert property (@(posedge clk) disable iff (rst)
    beat < BW'(LONG_BEATS));

  // R11
  cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cyc == $past(cyc) + W'(1));

endmodule

// File: tb/tcp_timed_copro_tb.sv
module tcp_timed_copro_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic        req_phase = 1'b0;
  logic [3:0]  req_cpnum = 4'd0;
  logic [31:0] req_instr = 32'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        resp_valid, resp_done, resp_busy, resp_more, resp_cant;
  logic [31:0] resp_rdata;
  logic        fiq_n, irq_n;

  always #5 clk = ~clk;

  tcp_timed_copro u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_phase(req_phase), .req_cpnum(req_cpnum), .req_instr(req_instr),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_done(resp_done),
    .resp_busy(resp_busy), .resp_more(resp_more), .resp_cant(resp_cant),
    .resp_rdata(resp_rdata), .fiq_n(fiq_n), .irq_n(irq_n)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R2";
  bit    finished = 0;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_reg [16];
  logic [31:0] m_time, m_finish;
  int          m_beat;
  bit          m_fpend, m_ipend;
  logic [31:0] m_fleft, m_ileft;
  logic        e_valid, e_fiq, e_irq;
  logic [3:0]  e_flags;   // {done,busy,more,cant}
  logic [31:0] e_rdata;
  string       e_tag = "R1";

  localparam logic [3:0] F_DONE = 4'b1000, F_BUSY = 4'b0100,
                         F_MORE = 4'b0010, F_CANT = 4'b0001;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_reg[i]) m_reg[i] = 32'd0;
      m_time = 0; m_finish = 0; m_beat = 0;
      m_fpend = 0; m_ipend = 0; m_fleft = 0; m_ileft = 0;
      e_valid = 0; e_flags = 0; e_rdata = 0; e_fiq = 1; e_irq = 1;
      e_tag = "R1";
    end else begin
      bit sf, si, cf, ci, f_fire, i_fire;
      logic [31:0] cnt;
      int op, mv, xf, ci_idx;
      sf = 0; si = 0; cf = 0; ci = 0;
      op = req_instr[23:20]; mv = req_instr[19:16];
      xf = req_instr[15:12]; ci_idx = req_instr[3:0];
      cnt = m_reg[ci_idx];
      e_valid = req_valid; e_flags = 0; e_rdata = 0;
      if (req_valid) begin
        e_tag = cur_tag;
        e_flags = F_CANT;
        if (req_cpnum == 4 || req_cpnum == 5) begin
          if (req_kind == 0) begin m_reg[mv] = req_wdata; e_flags = F_DONE; end
          else if (req_kind == 1) begin e_rdata = m_reg[mv]; e_flags = F_DONE; end
          else if ((req_kind == 2 || req_kind == 3) && req_cpnum == 4) begin
            if (!req_phase) begin m_beat = 0; e_flags = F_DONE; end
            else begin
              if (req_kind == 2) m_reg[xf] = req_wdata; else e_rdata = m_reg[xf];
              if (req_instr[22]) begin
                m_beat++;
                if (m_beat == 5) begin m_beat = 0; e_flags = F_DONE; end
                else e_flags = F_MORE;
              end else begin m_beat = 0; e_flags = F_DONE; end
            end
          end else if (req_kind == 4) begin
            if (op == 0) begin
              if (!req_phase) begin
                m_finish = m_time + cnt;
                e_flags = (cnt == 0) ? F_DONE : F_BUSY;
              end else e_flags = (m_time >= m_finish) ? F_DONE : F_BUSY;
            end else if (req_cpnum == 5) begin
              e_flags = F_DONE;
              case (op)
                1: sf = 1;
                2: si = 1;
                3: cf = 1;
                4: ci = 1;
                5: m_reg[ci_idx] = m_time;
                default: e_flags = F_CANT;
              endcase
            end
          end
        end
      end
      // fast line: schedule beats firing, firing beats release
      f_fire = m_fpend && m_fleft == 1;
      if (sf) begin
        if (cnt == 0) begin e_fiq = 0; m_fpend = 0; end
        else begin m_fpend = 1; m_fleft = cnt; end
      end else if (f_fire) begin e_fiq = 0; m_fpend = 0; end
      else begin
        if (m_fpend) m_fleft--;
        if (cf) e_fiq = 1;
      end
      i_fire = m_ipend && m_ileft == 1;
      if (si) begin
        if (cnt == 0) begin e_irq = 0; m_ipend = 0; end
        else begin m_ipend = 1; m_ileft = cnt; end
      end else if (i_fire) begin e_irq = 0; m_ipend = 0; end
      else begin
        if (m_ipend) m_ileft--;
        if (ci) e_irq = 1;
      end
      m_time++;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      check("R1", {31'd0, fiq_n}, 32'd1);
      check("R1", {31'd0, irq_n}, 32'd1);
      check("R1", {31'd0, resp_valid}, 32'd0);
    end else if (!finished) begin
      check("R13", {31'd0, resp_valid}, {31'd0, e_valid});
      check(e_tag, {28'd0, resp_done, resp_busy, resp_more, resp_cant}, {28'd0, e_flags});
      check(e_tag, resp_rdata, e_rdata);
      check("R8", {31'd0, fiq_n}, {31'd0, e_fiq});
      check("R9", {31'd0, irq_n}, {31'd0, e_irq});
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mk(int op, int crn, int crd, int crm);
    return {8'd0, 4'(op), 4'(crn), 4'(crd), 8'd0, 4'(crm)};
  endfunction

  task automatic req(string tag, int kind, bit ph, int cp, logic [31:0] ins, logic [31:0] wd);
    @(negedge clk);
    cur_tag = tag; req_valid = 1; req_kind = 3'(kind); req_phase = ph;
    req_cpnum = 4'(cp); req_instr = ins; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 registers read zero after reset
    req("R1", 1, 0, 4, mk(0, 0, 0, 0), 0);
    req("R1", 1, 0, 5, mk(0, 15, 0, 0), 0);
    // R2 moves on both numbers
    req("R2", 0, 0, 4, mk(0, 3, 0, 0), 32'h0000_00A5);
    req("R2", 1, 0, 5, mk(0, 3, 0, 0), 0);
    req("R2", 0, 0, 5, mk(0, 7, 0, 0), 32'd10);
    req("R2", 1, 0, 4, mk(0, 7, 0, 0), 0);
    // R3 foreign numbers and bad kinds
    req("R3", 0, 0, 6, mk(0, 3, 0, 0), 32'hDEAD);
    req("R3", 1, 0, 15, mk(0, 3, 0, 0), 0);
    req("R3", 7, 0, 4, mk(0, 3, 0, 0), 0);
    req("R2", 1, 0, 4, mk(0, 3, 0, 0), 0);
    // R4 short transfers
    req("R6", 2, 0, 4, mk(0, 0, 2, 0), 0);
    req("R4", 2, 1, 4, mk(0, 0, 2, 0), 32'h1234_5678);
    req("R6", 3, 0, 4, mk(0, 0, 2, 0), 0);
    req("R4", 3, 1, 4, mk(0, 0, 2, 0), 0);
    req("R4", 2, 0, 5, mk(0, 0, 2, 0), 0);
    req("R4", 3, 1, 5, mk(0, 0, 2, 0), 0);
    // R5 long load, then partial long restarted by address phase
    req("R6", 2, 0, 4, mk(4, 0, 9, 0), 0);
    for (int i = 0; i < 5; i++) req("R5", 2, 1, 4, mk(4, 0, 9, 0), 32'h100 + i);
    req("R6", 2, 0, 4, mk(4, 0, 9, 0), 0);
    for (int i = 0; i < 2; i++) req("R5", 2, 1, 4, mk(4, 0, 9, 0), 32'h200 + i);
    req("R6", 3, 0, 4, mk(4, 0, 9, 0), 0);
    for (int i = 0; i < 5; i++) req("R5", 3, 1, 4, mk(4, 0, 9, 0), 0);
    // R7 stalls: zero count, then ten cycles
    req("R7", 4, 0, 4, mk(0, 0, 0, 1), 0);
    req("R7", 4, 0, 5, mk(0, 0, 0, 7), 0);
    for (int i = 0; i < 12; i++) req("R7", 4, 1, 5, mk(0, 0, 0, 7), 0);
    // R10 coprocessor 4 rejects other opcodes, cp5 rejects high opcodes
    req("R10", 4, 0, 4, mk(1, 0, 0, 8), 0);
    req("R10", 4, 0, 5, mk(9, 0, 0, 8), 0);
    // R8 delayed fast interrupt, then release
    req("R2", 0, 0, 4, mk(0, 8, 0, 0), 32'd4);
    req("R8", 4, 0, 5, mk(1, 0, 0, 8), 0);
    idle(6);
    req("R10", 4, 0, 5, mk(3, 0, 0, 0), 0);
    // R9 immediate normal interrupt, then release
    req("R9", 4, 0, 5, mk(2, 0, 0, 1), 0);
    idle(2);
    req("R10", 4, 0, 5, mk(4, 0, 0, 0), 0);
    // R9 delayed normal interrupt
    req("R9", 4, 0, 5, mk(2, 0, 0, 8), 0);
    idle(6);
    req("R10", 4, 0, 5, mk(4, 0, 0, 0), 0);
    // R12 reschedule replaces pending
    req("R12", 4, 0, 5, mk(1, 0, 0, 8), 0);
    idle(1);
    req("R12", 4, 0, 5, mk(1, 0, 0, 8), 0);
    idle(6);
    req("R10", 4, 0, 5, mk(3, 0, 0, 0), 0);
    // R12 firing edge meets release: line stays low
    req("R2", 0, 0, 4, mk(0, 9, 0, 0), 32'd2);
    req("R12", 4, 0, 5, mk(1, 0, 0, 9), 0);
    req("R12", 4, 0, 5, mk(3, 0, 0, 0), 0);
    idle(3);
    req("R10", 4, 0, 5, mk(3, 0, 0, 0), 0);
    // R12 firing edge meets reschedule: reload wins
    req("R12", 4, 0, 5, mk(2, 0, 0, 9), 0);
    req("R12", 4, 0, 5, mk(2, 0, 0, 8), 0);
    idle(6);
    req("R10", 4, 0, 5, mk(4, 0, 0, 0), 0);
    // R11 snapshot of the cycle counter
    req("R11", 4, 0, 5, mk(5, 0, 0, 11), 0);
    req("R11", 1, 0, 4, mk(0, 11, 0, 0), 0);
    req("R11", 4, 0, 5, mk(5, 0, 0, 12), 0);
    idle(2);
    req("R11", 1, 0, 5, mk(0, 12, 0, 0), 0);
    idle(3);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule